// File: doc/BRIEF.md
# Fetch Sequencer with Optional Branch Delay Slot

This block is the program-counter and fetch sequencer of a 32-bit load/store core with two stages. While the execute stage works on the instruction at address A, the fetch stage has already requested the word at A+4 from a synchronous instruction memory. The sequencer decodes four control-transfer instructions itself: register jump-and-link, jump-and-link, plain jump, and branch-if-register-zero. It computes the next fetch address, drives a link-register write port and reports each executed address on a trace port.

A static mode input decides what happens to the word that is already prefetched when a transfer is taken. With the delay slot on, that word always executes and the link value is the transfer address plus 8. With the delay slot off, that word is discarded as a bubble, execution moves straight to the target, and the link value is the transfer address plus 4. A register file outside the block answers a single combinational read of the `rs` field. The block uses that value as the register-jump target and as the operand of the zero test.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `imem_req`, `exec_valid` and `link_we` are 0. The first fetch address is the parameter `RESET_VEC`. It is presented on `imem_addr` with `imem_req` high in the second cycle after release.
- R2: Without a taken transfer, consecutive fetch addresses step by 4. An instruction fetched in one cycle appears on `exec_pc` with `exec_valid` high in the next cycle, so executed addresses run A, A+4, A+8.
- R3: A word with bits 31:26 = 0 and bits 5:0 = 0x09 is a register jump-and-link. Its target is the full value read from the register named by bits 25:21 (`rs`). Its link goes to the register named by bits 15:11 (`rd`). For example, 0x0140F809 reads register 10 and links register 31.
- R4: Opcode 0x02 (bits 31:26) is a plain jump and opcode 0x03 is a jump-and-link. Both go to {(A+4)[31:28], bits 25:0, 2'b00}. The jump-and-link writes register 31; the plain jump writes no register.
- R5: Opcode 0x04 with bits 20:16 = 0 is branch-if-zero. It is taken only when the `rs` register reads 0. Its target is A+4 plus the sign-extended bits 15:0 shifted left by 2, so negative offsets reach lower addresses.
- R6: A link write (`link_we`) occurs only in the cycle the linking instruction executes. Its value is A+8 in delay-slot mode and A+4 otherwise. A register jump-and-link at 0x5000 links 0x5008 or 0x5004.
- R7: In delay-slot mode (`delay_slot_en` = 1), the instruction at A+4 after a taken transfer always executes, and the target executes next.
- R8: In delay-slot mode, a branch-if-zero that is not taken executes A+4 and then continues at A+8, the same order as in no-delay mode.
- R9: In no-delay mode, the word prefetched at A+4 after a taken transfer is a bubble. It raises no `exec_valid`, makes no link write and causes no redirect, and the target executes in the cycle after the bubble.
- R10: `rf_raddr` equals bits 25:21 of the instruction word currently in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_slot_en | input | 1 | Static mode: 1 = the word after a transfer executes, 0 = it is discarded |
| imem_req | output | 1 | Fetch request for this cycle |
| imem_addr | output | ADDR_W | Fetch address |
| imem_rdata | input | 32 | Word returned one cycle after the request |
| rf_raddr | output | 5 | Register index for the operand read |
| rf_rdata | input | ADDR_W | Value of the register at `rf_raddr` (combinational) |
| exec_valid | output | 1 | An instruction executes this cycle |
| exec_pc | output | ADDR_W | Address of the executing instruction |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | ADDR_W | Link value |

## Verification
An error in the fetch address register shows on `imem_addr` in the same cycle. It then shows on `exec_pc` in the next cycle as a break in the +4 sequence or as a wrong target. A wrong squash decision shows one cycle after the transfer: `exec_valid` is high in no-delay mode, or low in delay mode, where the slot should run. A wrong link offset or index shows on the link port in the very cycle the linking instruction executes. The directed programs therefore compare the executed-address trace entry by entry and compare every link write against its expected index and value.

// File: rtl/fs_pkg.sv
package fs_pkg;
   localparam int unsigned IW        = 32;
   localparam int unsigned RIDX_W    = 5;
   localparam logic [5:0]  OP_SPEC   = 6'h00;
   localparam logic [5:0]  OP_JMP    = 6'h02;
   localparam logic [5:0]  OP_JMPL   = 6'h03;
   localparam logic [5:0]  OP_BRZ    = 6'h04;
   localparam logic [5:0]  FN_JREGL  = 6'h09;

   typedef enum logic [2:0] {
      XF_NONE, XF_JMP, XF_JMPL, XF_JREGL, XF_BRZ
   } xfer_e;

   typedef struct packed {
      xfer_e               kind;
      logic [RIDX_W-1:0]   rs;
      logic [RIDX_W-1:0]   rd;
      logic [25:0]         idx;
      logic [15:0]         off;
   } dec_t;
endpackage

// File: rtl/fs_decode.sv
module fs_decode
   import fs_pkg::*;
(
   input  logic          valid,
   input  logic [IW-1:0] instr,
   output dec_t          dec
);
   logic [5:0] op;
   logic [5:0] fn;
   logic [4:0] rt;

   assign op = instr[31:26];
   assign fn = instr[5:0];
   assign rt = instr[20:16];

   always_comb begin
      dec.rs   = instr[25:21];
      dec.rd   = instr[15:11];
      dec.idx  = instr[25:0];
      dec.off  = instr[15:0];
      dec.kind = XF_NONE;
      if (valid) begin
         unique case (op)
            OP_SPEC: if (fn == FN_JREGL) dec.kind = XF_JREGL;
            OP_JMP:  dec.kind = XF_JMP;
            OP_JMPL: dec.kind = XF_JMPL;
            OP_BRZ:  if (rt == 5'd0) dec.kind = XF_BRZ;
            default: dec.kind = XF_NONE;
         endcase
      end
   end
endmodule

// File: rtl/fs_target.sv
module fs_target
   import fs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LINK_REG = 31
)(
   input  dec_t                 dec,
   input  logic [ADDR_W-1:0]    ex_pc,
   input  logic [ADDR_W-1:0]    rs_val,
   input  logic                 delay_en,
   output logic                 taken,
   output logic [ADDR_W-1:0]    target,
   output logic                 lwe,
   output logic [RIDX_W-1:0]    lidx,
   output logic [ADDR_W-1:0]    ldata
);
   localparam int unsigned SEXT_W = ADDR_W - 18;
   localparam logic [RIDX_W-1:0] LREG = RIDX_W'(LINK_REG);

   logic [ADDR_W-1:0] pc4, pc8, jtgt, btgt;

   assign pc4 = ex_pc + ADDR_W'(4);
   assign pc8 = ex_pc + ADDR_W'(8);

   generate
      if (ADDR_W > 28) begin : g_region
         assign jtgt = {pc4[ADDR_W-1:28], dec.idx, 2'b00};
      end else begin : g_flat
         assign jtgt = {dec.idx, 2'b00};
      end
   endgenerate

   assign btgt  = pc4 + {{SEXT_W{dec.off[15]}}, dec.off, 2'b00};
   assign ldata = delay_en ? pc8 : pc4;

   always_comb begin
      taken  = 1'b0;
      target = pc4;
      lwe    = 1'b0;
      lidx   = LREG;
      unique case (dec.kind)
         XF_JMP:   begin taken = 1'b1; target = jtgt; end
         XF_JMPL:  begin taken = 1'b1; target = jtgt; lwe = 1'b1; end
         XF_JREGL: begin taken = 1'b1; target = rs_val; lwe = 1'b1; lidx = dec.rd; end
         XF_BRZ:   begin taken = (rs_val == '0); target = btgt; end
         default:  ;
      endcase
   end
endmodule

// File: rtl/fs_pc_seq.sv
module fs_pc_seq #(
   parameter int unsigned         ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]   RESET_VEC = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              delay_en,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] target,
   output logic              run,
   output logic [ADDR_W-1:0] fetch_pc,
   output logic [ADDR_W-1:0] ex_pc,
   output logic              ex_valid
);
   logic squash;
   assign squash = redirect & ~delay_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         fetch_pc <= RESET_VEC;
         ex_pc    <= RESET_VEC;
         ex_valid <= 1'b0;
      end else begin
         run      <= 1'b1;
         if (run) fetch_pc <= redirect ? target : fetch_pc + ADDR_W'(4);
         ex_pc    <= fetch_pc;
         ex_valid <= run & ~squash;
      end
   end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
   import fs_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0000_5000),
   parameter int unsigned       LINK_REG  = 31
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              delay_slot_en,
   output logic              imem_req,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [IW-1:0]     imem_rdata,
   output logic [4:0]        rf_raddr,
   input  logic [ADDR_W-1:0] rf_rdata,
   output logic              exec_valid,
   output logic [ADDR_W-1:0] exec_pc,
   output logic              link_we,
   output logic [4:0]        link_idx,
   output logic [ADDR_W-1:0] link_data
);
   initial begin
      assert (ADDR_W >= 20 && ADDR_W <= 64)
         else $error("fetch_seq: ADDR_W out of range");
      assert (RESET_VEC[1:0] == 2'b00)
         else $error("fetch_seq: RESET_VEC must be word aligned");
      assert (LINK_REG < 32)
         else $error("fetch_seq: LINK_REG must index a register");
   end

   logic              run;
   logic              redirect;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] fetch_pc;
   dec_t              dec;

   fs_pc_seq #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_seq (
      .clk(clk), .rst_n(rst_n), .delay_en(delay_slot_en),
      .redirect(redirect), .target(target),
      .run(run), .fetch_pc(fetch_pc), .ex_pc(exec_pc), .ex_valid(exec_valid)
   );

   fs_decode u_dec (.valid(exec_valid), .instr(imem_rdata), .dec(dec));

   fs_target #(.ADDR_W(ADDR_W), .LINK_REG(LINK_REG)) u_tgt (
      .dec(dec), .ex_pc(exec_pc), .rs_val(rf_rdata), .delay_en(delay_slot_en),
      .taken(redirect), .target(target),
      .lwe(link_we), .lidx(link_idx), .ldata(link_data)
   );

   assign imem_req  = run;
   assign imem_addr = fetch_pc;
   assign rf_raddr  = imem_rdata[25:21];
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
   parameter int unsigned ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              delay_slot_en,
   input logic              imem_req,
   input logic [ADDR_W-1:0] imem_addr,
   input logic              exec_valid,
   input logic [ADDR_W-1:0] exec_pc,
   input logic              link_we,
   input logic              redirect,
   input logic [ADDR_W-1:0] target
);
   // R1: no request means nothing executes next cycle
   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !imem_req |=> !exec_valid);
   // R2: sequential fetch steps by one word
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_req && !redirect |=> imem_addr == $past(imem_addr) + ADDR_W'(4));
   // R2: fetched address executes one cycle later
   assert_exec_follows_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_req |=> exec_pc == $past(imem_addr));
   // R6: link writes only from an executing instruction
   assert_link_in_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> exec_valid);
   // R7: slot after a taken transfer runs in delay mode
   assert_slot_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect && delay_slot_en |=> exec_valid && exec_pc == $past(exec_pc) + ADDR_W'(4));
   // R9: bubble after a taken transfer in no-delay mode
   assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect && !delay_slot_en |=> !exec_valid && !link_we && !redirect);
   // R7: taken transfer moves fetch to its target
   assert_fetch_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> imem_addr == $past(target));
endmodule

bind fetch_seq fetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .delay_slot_en(delay_slot_en),
   .imem_req(imem_req), .imem_addr(imem_addr),
   .exec_valid(exec_valid), .exec_pc(exec_pc), .link_we(link_we),
   .redirect(redirect), .target(target)
);

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;
   localparam logic [31:0] RV = 32'h0000_5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        delay_slot_en = 1'b0;
   logic        imem_req;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata = '0;
   logic [4:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        exec_valid;
   logic [31:0] exec_pc;
   logic        link_we;
   logic [4:0]  link_idx;
   logic [31:0] link_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] mem [int unsigned];

   logic [31:0] tr_pc [16];
   logic        tr_lw [16];
   logic [4:0]  tr_li [16];
   logic [31:0] tr_ld [16];
   logic [4:0]  tr_ra [16];
   int          ntr = 0;
   int          nlink = 0;
   bit          collect = 1'b0;

   always #2 clk = ~clk;

   fetch_seq #(.ADDR_W(32), .RESET_VEC(RV), .LINK_REG(31)) u_dut (
      .clk(clk), .rst_n(rst_n), .delay_slot_en(delay_slot_en),
      .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .exec_valid(exec_valid), .exec_pc(exec_pc),
      .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
   );

   always @(posedge clk)
      if (imem_req) imem_rdata <= mem.exists(imem_addr) ? mem[imem_addr] : 32'h0;

   always_comb begin
      case (rf_raddr)
         5'd8:    rf_rdata = 32'h0;
         5'd9:    rf_rdata = 32'h5;
         5'd10:   rf_rdata = 32'h0000_6000;
         default: rf_rdata = 32'h0000_1234;
      endcase
   end

   always @(negedge clk) begin
      if (collect && exec_valid && ntr < 16) begin
         tr_pc[ntr] = exec_pc;
         tr_lw[ntr] = link_we;
         tr_li[ntr] = link_idx;
         tr_ld[ntr] = link_data;
         tr_ra[ntr] = rf_raddr;
         ntr++;
      end
      if (collect && link_we) nlink++;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_prog(bit mode, int cycles);
      collect = 1'b0;
      rst_n = 1'b0;
      delay_slot_en = mode;
      repeat (3) @(negedge clk);
      ntr = 0;
      nlink = 0;
      collect = 1'b1;
      rst_n = 1'b1;
      repeat (cycles) @(negedge clk);
      collect = 1'b0;
   endtask

   task automatic test_reset();
      mem.delete();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 req in reset", 32'(imem_req), 32'h0);
      check("R1 exec_valid in reset", 32'(exec_valid), 32'h0);
      check("R1 link_we in reset", 32'(link_we), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 req first cycle", 32'(imem_req), 32'h1);
      check("R1 first fetch addr", imem_addr, RV);
      check("R1 no exec yet", 32'(exec_valid), 32'h0);
      @(negedge clk);
      check("R2 first exec valid", 32'(exec_valid), 32'h1);
      check("R2 first exec pc", exec_pc, RV);
      check("R2 next fetch addr", imem_addr, RV + 32'd4);
   endtask

   task automatic test_jregl_delay();
      mem.delete();
      mem[32'h5000] = 32'h0140_F809;
      run_prog(1'b1, 10);
      check("R3 exec0 pc", tr_pc[0], 32'h5000);
      check("R10 rs read index", 32'(tr_ra[0]), 32'd10);
      check("R6 link we", 32'(tr_lw[0]), 32'h1);
      check("R3 link idx", 32'(tr_li[0]), 32'd31);
      check("R6 link value delay", tr_ld[0], 32'h5008);
      check("R7 slot executes", tr_pc[1], 32'h5004);
      check("R7 target after slot", tr_pc[2], 32'h6000);
      check("R2 sequential after target", tr_pc[3], 32'h6004);
      check("R6 single link write", 32'(nlink), 32'd1);
   endtask

   task automatic test_jregl_nodelay();
      mem.delete();
      mem[32'h5000] = 32'h0140_F809;
      mem[32'h5004] = 32'h0C00_1C00;
      run_prog(1'b0, 10);
      check("R6 link value nodelay", tr_ld[0], 32'h5004);
      check("R9 target directly", tr_pc[1], 32'h6000);
      check("R9 then sequential", tr_pc[2], 32'h6004);
      check("R9 squashed word no link", 32'(nlink), 32'd1);
   endtask

   task automatic test_jregl_rd();
      mem.delete();
      mem[32'h5000] = 32'h0140_4809;
      run_prog(1'b1, 8);
      check("R3 link idx from rd", 32'(tr_li[0]), 32'd9);
      check("R3 target from rs", tr_pc[2], 32'h6000);
   endtask

   task automatic test_jump_link();
      mem.delete();
      mem[32'h5000] = 32'h0C00_1800;
      run_prog(1'b1, 8);
      check("R4 jal link idx", 32'(tr_li[0]), 32'd31);
      check("R4 jal link delay", tr_ld[0], 32'h5008);
      check("R4 jal target delay", tr_pc[2], 32'h6000);
      run_prog(1'b0, 8);
      check("R4 jal link nodelay", tr_ld[0], 32'h5004);
      check("R4 jal target nodelay", tr_pc[1], 32'h6000);
   endtask

   task automatic test_plain_jump();
      mem.delete();
      mem[32'h5000] = 32'h0800_1800;
      run_prog(1'b0, 8);
      check("R4 jump target", tr_pc[1], 32'h6000);
      check("R4 jump no link", 32'(nlink), 32'd0);
   endtask

   task automatic test_brz();
      mem.delete();
      mem[32'h5000] = 32'h1100_03FF;
      run_prog(1'b1, 8);
      check("R5 taken slot", tr_pc[1], 32'h5004);
      check("R5 taken target", tr_pc[2], 32'h6000);
      mem[32'h5000] = 32'h1120_03FF;
      run_prog(1'b1, 8);
      check("R8 not taken slot", tr_pc[1], 32'h5004);
      check("R8 not taken continue", tr_pc[2], 32'h5008);
      run_prog(1'b0, 8);
      check("R5 not taken nodelay", tr_pc[1], 32'h5004);
      check("R5 not taken nodelay next", tr_pc[2], 32'h5008);
   endtask

   task automatic test_backward_loop();
      mem.delete();
      mem[32'h5000] = 32'h0800_1800;
      mem[32'h6000] = 32'h1100_FBFF;
      run_prog(1'b0, 10);
      check("R5 loop 1", tr_pc[1], 32'h6000);
      check("R5 backward target", tr_pc[2], 32'h5000);
      check("R5 loop again", tr_pc[3], 32'h6000);
      run_prog(1'b1, 12);
      check("R7 loop slot", tr_pc[1], 32'h5004);
      check("R7 loop target", tr_pc[2], 32'h6000);
      check("R7 branch slot", tr_pc[3], 32'h6004);
      check("R5 backward target delay", tr_pc[4], 32'h5000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_jregl_delay();
      test_jregl_nodelay();
      test_jregl_rd();
      test_jump_link();
      test_plain_jump();
      test_brz();
      test_backward_loop();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule